// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Capture and Compare

This block keeps a 16-bit up-counter that advances on a tick from a power-of-two prescaler. Two capture channels record the counter value when their input pin shows the selected edge. Two compare channels watch the counter for a match with their own register. The compare pair drives two output pins. In single mode each pin toggles on its own channel's match. In paired mode the two registers together shape one pulse on pin 0. A counter wrap, a capture event and a compare match each set a sticky flag, and each flag drives an interrupt request output.

Software configures the block through a small word-wide register port. A write takes effect at the rising clock edge on which the write strobe is high. Reads are combinational from the address. The address map is: 0 control, 1 counter, 2 flags, 3 capture 0, 4 capture 1, 5 compare 0, 6 compare 1. The control fields are: divide code in bits [2:0], run in bit 3, clear-on-compare-0 in bit 4, paired mode in bit 5, capture 0 edge code in bits [7:6], capture 1 edge code in bits [9:8]. The flag bits are: wrap in bit 0, capture i in bit 1+i, compare i in bit 3+i.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset the counter, control, flags, interrupt outputs and compare pins are all zero.
- R2: While control bit 3 is set with divide code d in bits [2:0], the counter advances once every 2^d clock cycles, so K running cycles add floor(K / 2^d). While bit 3 is clear the counter holds.
- R3: A tick taken while the counter holds 0xFFFF returns the counter to 0 and sets flag bit 0 and irq_ovf.
- R4: With control bit 4 set, a tick taken while the counter equals compare register 0 loads 0, so the count repeats with period compare0+1 ticks.
- R5: Capture channel i uses edge code 00 off, 01 rising, 10 falling, 11 both edges. The code sits in control bits [7:6] for channel 0 and [9:8] for channel 1. A selected edge copies the counter into capture register i (address 3+i) and sets flag bit 1+i.
- R6: A capture pin change becomes visible in the flags and the capture register at the third rising clock edge after the change, and not before.
- R7: A tick taken while the counter equals compare register i (address 5+i) sets flag bit 3+i at the same edge at which the counter leaves that value.
- R8: With control bit 5 clear, each compare pin toggles on its own channel's match.
- R9: With control bit 5 set, pin 0 rises on a compare 0 match and falls on a compare 1 match, and pin 1 stays low.
- R10: Writing the flag register (address 2) clears each flag whose written bit is 1 and leaves flags written with 0 unchanged.
- R11: Writing address 1 loads the counter, and the value reads back from address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational |
| cap_pin | input | 2 | Capture input pins |
| cmp_pin | output | 2 | Compare output pins |
| irq_ovf | output | 1 | Counter wrap request (sticky) |
| irq_cap | output | 2 | Capture requests (sticky) |
| irq_cmp | output | 2 | Compare requests (sticky) |

## Verification
A write lands on the rising edge after the bench raises the strobe, and the first tick follows one edge later. A counter loaded with v therefore reads v+n after n more edges at divide code 0. A compare flag and the matching pin change both appear on the edge where the counter steps past the compare value. A capture flag appears on the third edge after the pin changes. The bench changes inputs at the falling edge and reads results just after it. It counts edges explicitly, checks the capture flag both before and at its due edge, and compares pin levels against the counter value it reads in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam int ADDR_CTRL     = 0;
   localparam int ADDR_COUNT    = 1;
   localparam int ADDR_FLAGS    = 2;
   localparam int ADDR_CAP_BASE = 3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W:0]   one_hot;
   logic [PRE_W-1:0] mask;

   always_comb begin
      one_hot = (PRE_W+1)'(1) << sel;
      mask    = PRE_W'(one_hot - 1'b1);
      tick    = run && ((pre_q & mask) == mask);
   end

   // prescale phase restarts from zero whenever the counter is stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (run) pre_q <= pre_q + 1'b1;
      else          pre_q <= '0;
   end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  edge_sel_e        edge_sel,
   input  logic [CNT_W-1:0] count,
   output logic             hit,
   output logic [CNT_W-1:0] value
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   level, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= level;
      end
   end

   always_comb begin
      level = sync_q[SYNC_STAGES-1];
      rise  = level & ~prev_q;
      fall  = ~level & prev_q;
      hit   = ((edge_sel == EDGE_RISE || edge_sel == EDGE_BOTH) && rise) ||
              ((edge_sel == EDGE_FALL || edge_sel == EDGE_BOTH) && fall);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   value <= '0;
      else if (hit) value <= count;
   end
endmodule

// File: rtl/tmr_cmp_pair.sv
module tmr_cmp_pair #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             paired,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cmp_b,
   output logic             hit_a,
   output logic             hit_b,
   output logic             pin_a,
   output logic             pin_b
);
   always_comb begin
      hit_a = tick && (count == cmp_a);
      hit_b = tick && (count == cmp_b);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_a <= 1'b0;
         pin_b <= 1'b0;
      end else if (paired) begin
         // clear has priority when both registers hold the same value
         if (hit_b)      pin_a <= 1'b0;
         else if (hit_a) pin_a <= 1'b1;
         pin_b <= 1'b0;
      end else begin
         if (hit_a) pin_a <= ~pin_a;
         if (hit_b) pin_b <= ~pin_b;
      end
   end
endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SEL_W       = 3,
   parameter int N_CAP       = 2,
   parameter int N_CMP       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int N_REG      = ADDR_CAP_BASE + N_CAP + N_CMP,
   localparam int ADDR_W     = $clog2(N_REG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic [N_CAP-1:0]  cap_pin,
   output logic [N_CMP-1:0]  cmp_pin,
   output logic              irq_ovf,
   output logic [N_CAP-1:0]  irq_cap,
   output logic [N_CMP-1:0]  irq_cmp
);
   localparam int RUN_BIT   = SEL_W;
   localparam int CLR_BIT   = SEL_W + 1;
   localparam int PAIR_BIT  = SEL_W + 2;
   localparam int EDGE_LSB  = SEL_W + 3;
   localparam int CTRL_W    = EDGE_LSB + 2 * N_CAP;
   localparam int FLAG_W    = 1 + N_CAP + N_CMP;
   localparam int CAP_FLAG  = 1;
   localparam int CMP_FLAG  = 1 + N_CAP;
   localparam int CMP_BASE  = ADDR_CAP_BASE + N_CAP;
   localparam int N_PAIR    = N_CMP / 2;

   // elaboration-time parameter checks
   if (CTRL_W > CNT_W) begin : g_bad_ctrl
      $error("control fields do not fit in the register width");
   end
   if (FLAG_W > CNT_W) begin : g_bad_flag
      $error("flag bits do not fit in the register width");
   end
   if (N_CMP < 2 || (N_CMP % 2) != 0) begin : g_bad_cmp
      $error("compare channels must come in pairs");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("capture synchronizer needs at least two stages");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("prescale select width out of range");
   end

   logic [CTRL_W-1:0]  ctrl_q;
   logic [CNT_W-1:0]   count_q;
   logic [FLAG_W-1:0]  flags_q;
   logic [CNT_W-1:0]   cmp_q [N_CMP];
   logic [CNT_W-1:0]   cap_val [N_CAP];
   logic [N_CAP-1:0]   cap_hit;
   logic [N_CMP-1:0]   cmp_hit;
   logic               tick;
   logic               ovf_hit;
   logic               wr_ctrl, wr_count, wr_flags;
   logic [FLAG_W-1:0]  flag_set;

   always_comb begin
      wr_ctrl  = bus_we && (bus_addr == ADDR_W'(ADDR_CTRL));
      wr_count = bus_we && (bus_addr == ADDR_W'(ADDR_COUNT));
      wr_flags = bus_we && (bus_addr == ADDR_W'(ADDR_FLAGS));
      ovf_hit  = tick && (count_q == {CNT_W{1'b1}});
      flag_set = {cmp_hit, cap_hit, ovf_hit};
   end

   tmr_prescale #(.SEL_W(SEL_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl_q[RUN_BIT]),
      .sel   (ctrl_q[SEL_W-1:0]),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          count_q <= '0;
      else if (wr_count)                   count_q <= bus_wdata;
      else if (tick && ctrl_q[CLR_BIT] && cmp_hit[0]) count_q <= '0;
      else if (tick)                       count_q <= count_q + 1'b1;
   end

   // sticky flags: a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~(wr_flags ? bus_wdata[FLAG_W-1:0] : '0)) | flag_set;
   end

   for (genvar c = 0; c < N_CMP; c++) begin : g_cmp_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cmp_q[c] <= '0;
         else if (bus_we && bus_addr == ADDR_W'(CMP_BASE + c)) cmp_q[c] <= bus_wdata;
      end
   end

   for (genvar i = 0; i < N_CAP; i++) begin : g_cap
      tmr_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (cap_pin[i]),
         .edge_sel (edge_sel_e'(ctrl_q[EDGE_LSB + 2*i +: 2])),
         .count    (count_q),
         .hit      (cap_hit[i]),
         .value    (cap_val[i])
      );
   end

   for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
      tmr_cmp_pair #(.CNT_W(CNT_W)) u_pair (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .paired (ctrl_q[PAIR_BIT]),
         .count  (count_q),
         .cmp_a  (cmp_q[2*p]),
         .cmp_b  (cmp_q[2*p+1]),
         .hit_a  (cmp_hit[2*p]),
         .hit_b  (cmp_hit[2*p+1]),
         .pin_a  (cmp_pin[2*p]),
         .pin_b  (cmp_pin[2*p+1])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADDR_CTRL))  bus_rdata = CNT_W'(ctrl_q);
      if (bus_addr == ADDR_W'(ADDR_COUNT)) bus_rdata = count_q;
      if (bus_addr == ADDR_W'(ADDR_FLAGS)) bus_rdata = CNT_W'(flags_q);
      for (int i = 0; i < N_CAP; i++)
         if (bus_addr == ADDR_W'(ADDR_CAP_BASE + i)) bus_rdata = cap_val[i];
      for (int c = 0; c < N_CMP; c++)
         if (bus_addr == ADDR_W'(CMP_BASE + c)) bus_rdata = cmp_q[c];
   end

   assign irq_ovf = flags_q[0];
   assign irq_cap = flags_q[CAP_FLAG +: N_CAP];
   assign irq_cmp = flags_q[CMP_FLAG +: N_CMP];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             wr_count,
   input logic             wr_flags,
   input logic [CNT_W-1:0] wdata,
   input logic [CNT_W-1:0] count,
   input logic             clr_en,
   input logic             paired,
   input logic             hit0,
   input logic             hit1,
   input logic             pin0,
   input logic             pin1,
   input logic             irq_ovf
);
   // R3
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == {CNT_W{1'b1}}) |=> irq_ovf);

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_count && !(clr_en && hit0)) |=> (count == $past(count) + 1'b1));

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_count) |=> $stable(count));

   // R4
   clear_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && clr_en && hit0 && !wr_count) |=> (count == '0));

   // R9
   pair_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (paired && hit0 && !hit1) |=> pin0);

   // R9
   pair_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (paired && $past(paired)) |-> !pin1);

   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ovf && !(wr_flags && wdata[0])) |=> irq_ovf);
endmodule

bind cap_cmp_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .wr_count (wr_count),
   .wr_flags (wr_flags),
   .wdata    (bus_wdata),
   .count    (count_q),
   .clr_en   (ctrl_q[CLR_BIT]),
   .paired   (ctrl_q[PAIR_BIT]),
   .hit0     (cmp_hit[0]),
   .hit1     (cmp_hit[1]),
   .pin0     (cmp_pin[0]),
   .pin1     (cmp_pin[1]),
   .irq_ovf  (irq_ovf)
);

// File: tb/cap_cmp_timer_test.sv
module cap_cmp_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  cap_pin = '0;
   logic [1:0]  cmp_pin;
   logic        irq_ovf;
   logic [1:0]  irq_cap;
   logic [1:0]  irq_cmp;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cap_cmp_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
      .cmp_pin(cmp_pin), .irq_ovf(irq_ovf), .irq_cap(irq_cap), .irq_cmp(irq_cmp)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input int a, input int d);
      bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] v);
      bus_addr = 3'(a);
      #1 v = bus_rdata;
   endtask

   task automatic run_for(input int ctrl_run, input int ctrl_stop, input int k);
      wr(0, ctrl_run);
      repeat (k - 1) @(negedge clk);
      wr(0, ctrl_stop);
   endtask

   task automatic cap_test(input int ch, input int code);
      logic [15:0] v;
      int base;
      base = (ch == 0) ? 16'h0100 : 16'h0300;
      wr(0, code << (6 + 2*ch));
      wr(2, 16'h001F);
      // rising edge
      wr(1, base + code);
      cap_pin[ch] = 1'b1;
      repeat (2) @(negedge clk);
      rd(2, v);
      check(v[1+ch] == 1'b0, "R6 early", v[1+ch], 0);
      @(negedge clk);
      rd(2, v);
      check(v[1+ch] == code[0], "R5 rise flag", v[1+ch], code[0]);
      check(irq_cap[ch] == code[0], "R5 rise irq", irq_cap[ch], code[0]);
      if (code[0]) begin
         rd(3 + ch, v);
         check(v == 16'(base + code), "R5 rise value", v, base + code);
      end
      wr(2, 16'h001F);
      // falling edge
      wr(1, base + 16'h0080 + code);
      cap_pin[ch] = 1'b0;
      repeat (2) @(negedge clk);
      rd(2, v);
      check(v[1+ch] == 1'b0, "R6 early", v[1+ch], 0);
      @(negedge clk);
      rd(2, v);
      check(v[1+ch] == code[1], "R5 fall flag", v[1+ch], code[1]);
      if (code[1]) begin
         rd(3 + ch, v);
         check(v == 16'(base + 16'h0080 + code), "R5 fall value", v, base + 16'h0080 + code);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, v); check(v == 0, "R1 ctrl", v, 0);
      rd(1, v); check(v == 0, "R1 count", v, 0);
      rd(2, v); check(v == 0, "R1 flags", v, 0);
      check({irq_ovf, irq_cap, irq_cmp, cmp_pin} == 0, "R1 outputs",
            {irq_ovf, irq_cap, irq_cmp, cmp_pin}, 0);

      // R11 counter load
      wr(1, 16'h1234);
      rd(1, v); check(v == 16'h1234, "R11 load", v, 16'h1234);

      // R2 prescaler sweep
      wr(5, 16'h8000);
      wr(6, 16'h8001);
      for (int d = 0; d < 8; d++) begin
         wr(1, 0);
         run_for(8 | d, d, 300);
         rd(1, v); check(v == 16'(300 >> d), "R2 divide", v, 300 >> d);
         repeat (10) @(negedge clk);
         rd(1, v); check(v == 16'(300 >> d), "R2 hold", v, 300 >> d);
      end

      // R3 wrap
      wr(2, 16'h001F);
      wr(1, 16'hFFFE);
      run_for(8, 0, 3);
      rd(1, v); check(v == 1, "R3 count", v, 1);
      rd(2, v); check(v[0] == 1'b1, "R3 flag", v[0], 1);
      check(irq_ovf == 1'b1, "R3 irq", irq_ovf, 1);

      // R10 write-one-to-clear
      wr(2, 16'h0000);
      rd(2, v); check(v[0] == 1'b1, "R10 zero keeps", v[0], 1);
      wr(2, 16'h0001);
      rd(2, v); check(v[0] == 1'b0, "R10 one clears", v[0], 0);

      // R9 paired waveform
      wr(5, 10);
      wr(6, 20);
      wr(1, 0);
      wr(0, 16'h0028);
      for (int n = 0; n <= 40; n++) begin
         rd(1, v);
         check(cmp_pin[0] == (v >= 11 && v <= 20), "R9 pin0", cmp_pin[0], (v >= 11 && v <= 20));
         check(cmp_pin[1] == 1'b0, "R9 pin1", cmp_pin[1], 0);
         @(negedge clk);
      end
      wr(0, 0);

      // R8 single-mode toggles
      wr(1, 0);
      wr(0, 16'h0008);
      for (int n = 0; n <= 40; n++) begin
         rd(1, v);
         check(cmp_pin[0] == (v >= 11), "R8 pin0", cmp_pin[0], (v >= 11));
         check(cmp_pin[1] == (v >= 21), "R8 pin1", cmp_pin[1], (v >= 21));
         @(negedge clk);
      end
      wr(0, 0);

      // R7 compare flag timing
      wr(2, 16'h001F);
      wr(5, 100);
      wr(1, 97);
      wr(0, 16'h0008);
      repeat (3) @(negedge clk);
      rd(2, v); check(v[3] == 1'b0, "R7 before match", v[3], 0);
      @(negedge clk);
      rd(2, v); check(v[3] == 1'b1, "R7 match flag", v[3], 1);
      check(irq_cmp[0] == 1'b1, "R7 irq", irq_cmp[0], 1);
      wr(0, 0);

      // R4 clear on compare 0
      wr(5, 5);
      wr(6, 16'h8001);
      for (int k = 1; k <= 12; k++) begin
         wr(1, 3);
         run_for(16'h0018, 16'h0010, k);
         rd(1, v); check(v == 16'((3 + k) % 6), "R4 period", v, (3 + k) % 6);
      end
      wr(0, 0);

      // R5 and R6 capture edge codes on both channels
      for (int ch = 0; ch < 2; ch++)
         for (int code = 0; code < 4; code++)
            cap_test(ch, code);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule